// File: doc/BRIEF.md
# Alert Class Escalation Sequencer

This block serves one alert class. It counts the alert triggers of the class in a saturating accumulator. When an alert arrives while the count has already reached a programmed threshold, it starts a timed escalation sequence made of four phases. A second path can also start escalation. If the class interrupt stays pending, the block waits in a timeout state and starts escalation once a programmed number of cycles has passed. The waiting and the phase timing use the same cycle counter.

Four escalation enables leave the block. Each one is asserted during the phase that its own two-bit map entry selects, and only while its own enable bit is set. A clear request resets the accumulator and returns the sequencer to idle, but only while clear is permitted. If the lock input is set when escalation starts, clearing is forbidden until the next reset. After the last phase the sequencer parks in a terminal state with every enable low.

All pins are plain control and status levels. There is no streaming data and no handshake. Configuration inputs are expected to hold steady while the class is in use.

Top module: `esc_class_ctrl`

## Requirements
- R1: The accumulation count on `accu_cnt_o` rises by exactly one on each clock edge where `trig_i` and `class_en_i` are both high. It saturates at 2^ACCU_W-1 and never wraps. Triggers arriving while `class_en_i` is low leave the count unchanged.
- R2: Escalation starts on an enabled trigger that arrives while the count is at least `accu_thresh_i`. With a threshold of 0, the first alert starts it. With a threshold of N, the (N+1)th alert starts it.
- R3: In Idle, if `irq_pend_i` and `class_en_i` are high and `timeout_i` is nonzero, the sequencer enters Timeout with the counter at 1. The counter then rises by one each cycle, and the edge that finds it at or above `timeout_i` moves the sequencer to Phase0. A `timeout_i` of 0 keeps the sequencer in Idle.
- R4: The clock edge that samples the starting condition moves `state_o` to Phase0 and sets `esc_cnt_o` to 1.
- R5: Phase k lasts max(`phase_cyc_i[k]`,1) cycles, with `esc_cnt_o` counting 1, 2, and so on within the phase. Phase3 is followed by Terminal, where the counter reads 0.
- R6: Timeout and escalation share one counter, and an alert trigger takes priority over the timeout. A starting trigger in Idle or in Timeout goes to Phase0 at once, even while an interrupt is pending.
- R7: `esc_o[i]` is high exactly when `out_en_i[i]` is set and the current phase index (Phase0=0 through Phase3=3) equals `out_map_i[i]`. In every other state all enables are low.
- R8: `clr_i` returns the sequencer to Idle and zeroes the accumulator and the counter on the next edge, but only while `clr_en_i` is high. With `clr_en_i` low, the request has no effect.
- R9: If `lock_i` is high when escalation starts, later clear requests are ignored until reset. The sequencer runs on to Terminal and stays there.
- R10: Dropping `irq_pend_i` during Timeout returns the sequencer to Idle with the counter at 0.
- R11: Terminal holds, with all enables low, until a permitted clear arrives.
- R12: After reset the sequencer is Idle, and both counts and all enables are 0. The `state_o` codes are: Idle=0, Timeout=1, Phase0=2, Phase1=3, Phase2=4, Phase3=5, Terminal=6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| class_en_i | input | 1 | Class enable |
| lock_i | input | 1 | Forbid clearing once escalation starts |
| clr_en_i | input | 1 | Clear permitted |
| trig_i | input | 1 | OR of the alert triggers of this class |
| irq_pend_i | input | 1 | Class interrupt pending |
| clr_i | input | 1 | Clear request |
| accu_thresh_i | input | ACCU_W | Accumulation threshold |
| timeout_i | input | CNT_W | Interrupt timeout in cycles, 0 turns the timeout off |
| phase_cyc_i | input | 4 x CNT_W | Duration of each phase |
| out_en_i | input | NUM_OUT | Enable for each escalation output |
| out_map_i | input | NUM_OUT x 2 | Phase selected for each output |
| esc_o | output | NUM_OUT | Escalation enables |
| state_o | output | 3 | Sequencer state code |
| accu_cnt_o | output | ACCU_W | Accumulation count |
| esc_cnt_o | output | CNT_W | Shared timeout and phase counter |

## Verification
Four patterns exercise the main function.

- **Trigger bursts against a threshold.** Separated and back-to-back triggers are applied against thresholds of 0, 2 and 7. This shows whether the off-by-one at the threshold is right and whether the count saturates instead of wrapping.
- **Pending interrupt alone.** The interrupt is held pending with timeouts of 0, 3 and 5, and is sometimes dropped early. This separates a timeout that fires from one that is disabled or cancelled.
- **Pending interrupt plus a trigger.** A trigger arrives while the interrupt is pending. This shows that escalation takes priority over the timeout.
- **Full phase walk.** Unequal phase lengths, including a zero, are used first with the identity map and then with a permuted map that has one output masked. This shows whether each phase lasts the right time and whether each output follows its own map entry rather than its index.

Clear is tried in three cases: with clear permitted, with clear not permitted, and after a locked start.

// File: rtl/esc_ctrl_pkg.sv
package esc_ctrl_pkg;
  localparam int unsigned NUM_PHASES = 4;
  localparam int unsigned PH_W       = $clog2(NUM_PHASES);

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_TIMEOUT = 3'd1,
    ST_PH0     = 3'd2,
    ST_PH1     = 3'd3,
    ST_PH2     = 3'd4,
    ST_PH3     = 3'd5,
    ST_TERM    = 3'd6
  } esc_state_e;

  function automatic logic is_phase(esc_state_e s);
    return (s >= ST_PH0) && (s <= ST_PH3);
  endfunction

  function automatic logic [PH_W-1:0] phase_idx(esc_state_e s);
    logic [2:0] d;
    d = 3'(s) - 3'(ST_PH0);
    return d[PH_W-1:0];
  endfunction
endpackage

// File: rtl/esc_accum.sv
module esc_accum #(
  parameter int unsigned ACCU_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              trig_i,
  input  logic              clr_i,
  input  logic [ACCU_W-1:0] thresh_i,
  output logic [ACCU_W-1:0] cnt_o,
  output logic              fire_o
);
  localparam logic [ACCU_W-1:0] CntMax = '1;

  logic hit;
  assign hit    = en_i && trig_i;
  assign fire_o = hit && (cnt_o >= thresh_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= '0;
    end else if (clr_i) begin
      cnt_o <= '0;
    end else if (hit && (cnt_o != CntMax)) begin
      cnt_o <= cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/esc_seq.sv
module esc_seq
  import esc_ctrl_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             en_i,
  input  logic                             fire_i,
  input  logic                             pend_i,
  input  logic                             clr_i,
  input  logic [CNT_W-1:0]                 timeout_i,
  input  logic [NUM_PHASES-1:0][CNT_W-1:0] phase_cyc_i,
  output esc_state_e                       state_o,
  output logic [CNT_W-1:0]                 cnt_o,
  output logic                             start_o
);
  localparam logic [CNT_W-1:0] One = CNT_W'(1);

  esc_state_e       nxt_st;
  logic [CNT_W-1:0] nxt_cnt;
  logic [CNT_W-1:0] cur_len;

  assign cur_len = phase_cyc_i[phase_idx(state_o)];

  always_comb begin
    nxt_st  = state_o;
    nxt_cnt = cnt_o;
    start_o = 1'b0;
    if (clr_i) begin
      nxt_st  = ST_IDLE;
      nxt_cnt = '0;
    end else begin
      unique case (state_o)
        ST_IDLE: begin
          if (fire_i) begin
            nxt_st  = ST_PH0;
            nxt_cnt = One;
            start_o = 1'b1;
          end else if (en_i && pend_i && (timeout_i != '0)) begin
            nxt_st  = ST_TIMEOUT;
            nxt_cnt = One;
          end
        end
        ST_TIMEOUT: begin
          if (fire_i || (pend_i && (cnt_o >= timeout_i))) begin
            nxt_st  = ST_PH0;
            nxt_cnt = One;
            start_o = 1'b1;
          end else if (!pend_i) begin
            nxt_st  = ST_IDLE;
            nxt_cnt = '0;
          end else begin
            nxt_cnt = cnt_o + One;
          end
        end
        ST_PH0, ST_PH1, ST_PH2, ST_PH3: begin
          if (cnt_o >= cur_len) begin
            if (state_o == ST_PH3) begin
              nxt_st  = ST_TERM;
              nxt_cnt = '0;
            end else begin
              nxt_st  = esc_state_e'(3'(state_o) + 3'd1);
              nxt_cnt = One;
            end
          end else begin
            nxt_cnt = cnt_o + One;
          end
        end
        default: begin
          nxt_st  = ST_TERM;
          nxt_cnt = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_o <= ST_IDLE;
      cnt_o   <= '0;
    end else begin
      state_o <= nxt_st;
      cnt_o   <= nxt_cnt;
    end
  end
endmodule

// File: rtl/esc_outmap.sv
module esc_outmap
  import esc_ctrl_pkg::*;
#(
  parameter int unsigned NUM_OUT = 4
) (
  input  esc_state_e                   state_i,
  input  logic [NUM_OUT-1:0]           out_en_i,
  input  logic [NUM_OUT-1:0][PH_W-1:0] out_map_i,
  output logic [NUM_OUT-1:0]           esc_o
);
  logic            active;
  logic [PH_W-1:0] idx;

  assign active = is_phase(state_i);
  assign idx    = phase_idx(state_i);

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
    assign esc_o[g] = active && out_en_i[g] && (out_map_i[g] == idx);
  end
endmodule

// File: rtl/esc_class_ctrl.sv
module esc_class_ctrl
  import esc_ctrl_pkg::*;
#(
  parameter int unsigned ACCU_W  = 16,
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned NUM_OUT = 4
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             class_en_i,
  input  logic                             lock_i,
  input  logic                             clr_en_i,
  input  logic                             trig_i,
  input  logic                             irq_pend_i,
  input  logic                             clr_i,
  input  logic [ACCU_W-1:0]                accu_thresh_i,
  input  logic [CNT_W-1:0]                 timeout_i,
  input  logic [NUM_PHASES-1:0][CNT_W-1:0] phase_cyc_i,
  input  logic [NUM_OUT-1:0]               out_en_i,
  input  logic [NUM_OUT-1:0][PH_W-1:0]     out_map_i,
  output logic [NUM_OUT-1:0]               esc_o,
  output logic [2:0]                       state_o,
  output logic [ACCU_W-1:0]                accu_cnt_o,
  output logic [CNT_W-1:0]                 esc_cnt_o
);
  logic       clr_lock;
  logic       clr_ok;
  logic       fire;
  logic       start;
  esc_state_e st;

  assign clr_ok = clr_i && clr_en_i && !clr_lock;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clr_lock <= 1'b0;
    end else if (start && lock_i) begin
      clr_lock <= 1'b1;
    end
  end

  esc_accum #(.ACCU_W(ACCU_W)) u_accum (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (class_en_i),
    .trig_i   (trig_i),
    .clr_i    (clr_ok),
    .thresh_i (accu_thresh_i),
    .cnt_o    (accu_cnt_o),
    .fire_o   (fire)
  );

  esc_seq #(.CNT_W(CNT_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (class_en_i),
    .fire_i      (fire),
    .pend_i      (irq_pend_i),
    .clr_i       (clr_ok),
    .timeout_i   (timeout_i),
    .phase_cyc_i (phase_cyc_i),
    .state_o     (st),
    .cnt_o       (esc_cnt_o),
    .start_o     (start)
  );

  esc_outmap #(.NUM_OUT(NUM_OUT)) u_outmap (
    .state_i   (st),
    .out_en_i  (out_en_i),
    .out_map_i (out_map_i),
    .esc_o     (esc_o)
  );

  assign state_o = 3'(st);
endmodule

// File: rtl/esc_class_ctrl_chk.sv
module esc_class_ctrl_chk #(
  parameter int unsigned ACCU_W  = 16,
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned NUM_OUT = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               clr_i,
  input logic               fire,
  input logic               clr_lock,
  input logic [CNT_W-1:0]   timeout_i,
  input logic [NUM_OUT-1:0] esc_o,
  input logic [2:0]         state_o,
  input logic [ACCU_W-1:0]  accu_cnt_o,
  input logic [CNT_W-1:0]   esc_cnt_o
);
  localparam logic [ACCU_W-1:0] AccuMax = '1;

  AST_ACCU_SATURATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accu_cnt_o == AccuMax) && !clr_i |=> accu_cnt_o == AccuMax); // R1

  AST_ACCU_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (accu_cnt_o >= $past(accu_cnt_o)) &&
               ((accu_cnt_o - $past(accu_cnt_o)) <= ACCU_W'(1))); // R1

  AST_PH0_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd0) && fire && !clr_i |=> (state_o == 3'd2) && (esc_cnt_o == CNT_W'(1))); // R4

  AST_TERM_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 3'd6 |-> esc_o == '0); // R11

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o < 3'd2) |-> esc_o == '0); // R7

  AST_LOCK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_lock && (state_o != 3'd0) |=> state_o != 3'd0); // R9

  AST_TIMEOUT_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd0) && (timeout_i == '0) |=> state_o != 3'd1); // R3
endmodule

bind esc_class_ctrl esc_class_ctrl_chk #(
  .ACCU_W(ACCU_W), .CNT_W(CNT_W), .NUM_OUT(NUM_OUT)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .clr_i      (clr_i),
  .fire       (fire),
  .clr_lock   (clr_lock),
  .timeout_i  (timeout_i),
  .esc_o      (esc_o),
  .state_o    (state_o),
  .accu_cnt_o (accu_cnt_o),
  .esc_cnt_o  (esc_cnt_o)
);

// File: tb/test_esc_class_ctrl.sv
module test_esc_class_ctrl;
  localparam int ACCU_W = 3;
  localparam int CNT_W  = 8;
  localparam int NO     = 4;
  localparam int IDLE = 0, TMO = 1, P0 = 2, P1 = 3, P2 = 4, P3 = 5, TERM = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic class_en, lock, clr_en, trig, pend, clr;
  logic [ACCU_W-1:0]       thresh;
  logic [CNT_W-1:0]        tmo;
  logic [3:0][CNT_W-1:0]   pcyc;
  logic [NO-1:0]           oen;
  logic [NO-1:0][1:0]      omap;
  logic [NO-1:0]           esc;
  logic [2:0]              st;
  logic [ACCU_W-1:0]       accu;
  logic [CNT_W-1:0]        cnt;

  always #10 clk = ~clk;

  esc_class_ctrl #(.ACCU_W(ACCU_W), .CNT_W(CNT_W), .NUM_OUT(NO)) i_esc_class_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .class_en_i(class_en), .lock_i(lock),
    .clr_en_i(clr_en), .trig_i(trig), .irq_pend_i(pend), .clr_i(clr),
    .accu_thresh_i(thresh), .timeout_i(tmo), .phase_cyc_i(pcyc),
    .out_en_i(oen), .out_map_i(omap), .esc_o(esc), .state_o(st),
    .accu_cnt_o(accu), .esc_cnt_o(cnt)
  );

  typedef struct {
    int    st;
    int    esc;
    int    accu;
    int    cnt;
    string tag;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0;
  int   n_err = 0;
  bit   done  = 1'b0;

  // monitor: one comparison per clock edge, 5 ns after it
  always @(posedge clk) begin
    #5;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_chk++;
      if ((e.st >= 0 && int'(st) != e.st) || (e.esc >= 0 && int'(esc) != e.esc) ||
          (e.accu >= 0 && int'(accu) != e.accu) || (e.cnt >= 0 && int'(cnt) != e.cnt)) begin
        n_err++;
        $display("FAIL %s: got st=%0d esc=%b accu=%0d cnt=%0d exp st=%0d esc=%0d accu=%0d cnt=%0d",
                 e.tag, st, esc, accu, cnt, e.st, e.esc, e.accu, e.cnt);
      end
    end
  end

  // driver: expected values after the coming edge, then move to the next negedge
  task automatic step(int s, int e, int a, int c, string tag);
    exp_t x;
    x.st = s; x.esc = e; x.accu = a; x.cnt = c; x.tag = tag;
    q.push_back(x);
    @(negedge clk);
  endtask

  task automatic do_clear();
    clr = 1'b1;
    step(IDLE, 0, 0, 0, "R8 clear");
    clr = 1'b0;
  endtask

  initial begin
    #(20 * 20000);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    class_en = 1; lock = 0; clr_en = 1; trig = 0; pend = 0; clr = 0;
    thresh = 3'd2; tmo = '0;
    pcyc[0] = 8'd2; pcyc[1] = 8'd0; pcyc[2] = 8'd3; pcyc[3] = 8'd1;
    oen = 4'hF;
    for (int i = 0; i < NO; i++) omap[i] = 2'(i);
    @(negedge clk);
    step(IDLE, 0, 0, 0, "R12 reset");
    rst_n = 1'b1;

    // threshold 2 and a full phase walk with the identity map
    trig = 1; step(IDLE, 0, 1, 0, "R1 count");
    trig = 0; step(IDLE, 0, 1, 0, "R1 hold");
    trig = 1; step(IDLE, 0, 2, 0, "R2 below");
    step(P0, 1, 3, 1, "R2 R4 start");
    trig = 0;
    step(P0, 1, 3, 2, "R5 p0");
    step(P1, 2, 3, 1, "R5 p1 zero len");
    step(P2, 4, 3, 1, "R5 p2");
    step(P2, 4, 3, 2, "R5 p2");
    step(P2, 4, 3, 3, "R5 p2");
    step(P3, 8, 3, 1, "R5 p3");
    step(TERM, 0, 3, 0, "R5 term");
    step(TERM, 0, 3, 0, "R11 hold");
    do_clear();

    // disabled class ignores triggers
    class_en = 0; trig = 1;
    step(IDLE, 0, 0, 0, "R1 disabled");
    class_en = 1; trig = 0;

    // saturation with threshold 7
    thresh = 3'd7; trig = 1;
    for (int i = 1; i <= 7; i++) step(IDLE, 0, i, 0, "R1 climb");
    step(P0, -1, 7, 1, "R1 R2 saturate");
    step(P0, -1, 7, 2, "R1 saturated");
    trig = 0;
    do_clear();

    // threshold 0 fires on the first alert
    thresh = 3'd0; trig = 1;
    step(P0, 1, 1, 1, "R2 zero thresh");
    trig = 0;
    do_clear();

    // interrupt timeout
    thresh = 3'd7; tmo = 8'd3; pend = 1;
    step(TMO, 0, 0, 1, "R3 t1");
    step(TMO, 0, 0, 2, "R3 t2");
    step(TMO, 0, 0, 3, "R3 t3");
    step(P0, 1, 0, 1, "R3 expire");
    pend = 0;
    do_clear();

    tmo = 8'd5; pend = 1;
    step(TMO, 0, 0, 1, "R10 t1");
    step(TMO, 0, 0, 2, "R10 t2");
    pend = 0;
    step(IDLE, 0, 0, 0, "R10 drop");

    tmo = 8'd0; pend = 1;
    step(IDLE, 0, 0, 0, "R3 off");
    step(IDLE, 0, 0, 0, "R3 off");
    pend = 0;

    // escalation over timeout
    thresh = 3'd0; tmo = 8'd5; pend = 1;
    step(TMO, 0, 0, 1, "R6 wait");
    trig = 1;
    step(P0, 1, 1, 1, "R6 preempt");
    trig = 0; pend = 0;
    do_clear();
    pend = 1; trig = 1;
    step(P0, 1, 1, 1, "R6 same cycle");
    trig = 0; pend = 0;
    do_clear();

    // remapped outputs, output 1 masked
    omap[0] = 2'd3; omap[1] = 2'd1; omap[2] = 2'd2; omap[3] = 2'd0;
    oen = 4'b1101; trig = 1;
    step(P0, 8, 1, 1, "R7 p0");
    trig = 0;
    step(P0, 8, 1, 2, "R7 p0");
    step(P1, 0, 1, 1, "R7 masked");
    step(P2, 4, 1, 1, "R7 p2");
    step(P2, 4, 1, 2, "R7 p2");
    step(P2, 4, 1, 3, "R7 p2");
    step(P3, 1, 1, 1, "R7 p3");
    step(TERM, 0, 1, 0, "R7 term");
    do_clear();
    oen = 4'hF;
    for (int i = 0; i < NO; i++) omap[i] = 2'(i);

    // clear not permitted
    clr_en = 0; trig = 1;
    step(P0, 1, 1, 1, "R8 start");
    trig = 0; clr = 1;
    step(P0, 1, 1, 2, "R8 ignored");
    step(P1, 2, 1, 1, "R8 ignored");
    clr_en = 1;
    step(IDLE, 0, 0, 0, "R8 allowed");
    clr = 0;

    // locked start
    lock = 1; trig = 1;
    step(P0, 1, 1, 1, "R9 start");
    trig = 0; clr = 1;
    step(P0, 1, 1, 2, "R9 locked");
    step(P1, 2, 1, 1, "R9 locked");
    step(P2, 4, 1, 1, "R9 locked");
    step(P2, 4, 1, 2, "R9 locked");
    step(P2, 4, 1, 3, "R9 locked");
    step(P3, 8, 1, 1, "R9 locked");
    step(TERM, 0, 1, 0, "R9 term");
    step(TERM, 0, 1, 0, "R9 R11 stays");
    clr = 0; lock = 0;
    rst_n = 0;
    step(IDLE, 0, 0, 0, "R12 reset again");
    rst_n = 1;
    clr = 1;
    step(IDLE, 0, 0, 0, "R12 after reset");
    clr = 0;
    step(IDLE, 0, 0, 0, "R12 idle");
    @(negedge clk);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule